// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop is in lock. It watches the rising edges of the divided reference and the divided feedback clocks, the two signals that reach the phase detector, and measures how far apart they are in cycles of a fast sample clock. Both inputs first pass through a synchronizer of the same depth, so the measured distance is not skewed. A pairing state machine turns each reference/feedback edge pair into one separation count. A second state machine applies hysteresis to those counts. A pair that is closer than a tight lock window declares lock. Only a pair that is at least as far apart as a wider unlock window declares loss of lock. Pairs that fall between the two windows leave the state as it was.

Two window pairs are built in and `win_sel` picks one of them. The defaults assume a 1 ns sample clock. With `win_sel` = 0 the lock window is 10 cycles and the unlock window is 15 cycles. With `win_sel` = 1 they are 4 and 7 cycles. Raising `det_off` forces the detector into the unlocked state. The `status` output drives a status pin and can be active high or active low.

When the reference stops, no pair ever completes, so no separation is measured and a held lock is not dropped. The pairing machine has the states PAIR_IDLE, PAIR_WAIT_FB (a reference edge came first) and PAIR_WAIT_REF (a feedback edge came first). Its transitions are:
- start-ref: PAIR_IDLE to PAIR_WAIT_FB.
- start-fb: PAIR_IDLE to PAIR_WAIT_REF.
- coincident: stay in PAIR_IDLE when both edges arrive together, with a separation of 0.
- close: back to PAIR_IDLE when the partner edge arrives.
- repeat: stay in the waiting state when the same side fires again.

The hysteresis machine has the states LK_UNLOCKED and LK_LOCKED. Its transitions are:
- acquire: LK_UNLOCKED to LK_LOCKED.
- lose: LK_LOCKED to LK_UNLOCKED.
- disable: any state to LK_UNLOCKED.
- hold: stay in the current state.

Top module: `dld_lock_detect`

## Requirements
- R1: After reset the detector is unlocked, so `status` equals `pol_low`.
- R2: The separation of a pair is the number of sample cycles from the first rising edge to the second. It does not depend on which input leads, and edges in the same cycle give 0.
- R3: With `win_sel` = 0, a pair whose separation is below 10 cycles declares lock.
- R4: With `win_sel` = 0, a pair whose separation is 15 cycles or more declares loss of lock.
- R5: A pair whose separation is at least the lock window and below the unlock window leaves the lock state unchanged.
- R6: With `win_sel` = 1, the lock window is 4 cycles and the unlock window is 7 cycles.
- R7: While `det_off` is 1 the detector is held unlocked. After `det_off` returns to 0 it stays unlocked until a new pair qualifies for lock.
- R8: `status` is the lock flag when `pol_low` is 0 and its inverse when `pol_low` is 1.
- R9: Feedback edges with no reference edge complete no pair and leave a held lock in place. A reference edge that arrives later completes the pair with a large separation and declares loss of lock.
- R10: Further edges on the leading input while its partner is awaited do not restart the separation count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Divided reference clock, asynchronous |
| fb_in | input | 1 | Divided feedback clock, asynchronous |
| win_sel | input | 1 | Window pair select: 0 gives the wide pair, 1 gives the narrow pair |
| det_off | input | 1 | 1 disables detection and forces unlocked |
| pol_low | input | 1 | 1 makes `status` active low |
| status | output | 1 | Lock indication after the polarity is applied |

## Verification
The main function is driven with edge pairs whose separations sit exactly at each window boundary, with either input leading and with coincident edges. These show an off-by-one in a threshold, an ordering asymmetry and a wrong window pair apart. Random pairs with random lead, spacing, window set and polarity are compared against a hysteresis model and show up hold-state errors that a single step would hide. Directed sequences with feedback edges only and with a repeated reference edge separate a meter that measures correctly from one that times out or restarts its count.

// File: rtl/dld_pkg.sv
package dld_pkg;

    // Pairing machine: which edge, if any, is waiting for its partner
    typedef enum logic [1:0] {
        PAIR_IDLE     = 2'd0,
        PAIR_WAIT_FB  = 2'd1,
        PAIR_WAIT_REF = 2'd2
    } pair_st_t;

    // Hysteresis machine
    typedef enum logic {
        LK_UNLOCKED = 1'b0,
        LK_LOCKED   = 1'b1
    } lock_st_t;

endpackage

// File: rtl/dld_edge_det.sv
// Per-channel synchronizer followed by a rising-edge detector.
module dld_edge_det #(
    parameter int CHANNELS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] sig_in,
    output logic [CHANNELS-1:0] rise
);

    genvar ch;
    generate
        for (ch = 0; ch < CHANNELS; ch++) begin : g_ch
            logic synced;
            logic prev;

            if (SYNC_STAGES > 0) begin : g_sync
                logic [SYNC_STAGES-1:0] chain;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        chain <= '0;
                    end else begin
                        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], sig_in[ch]} & {SYNC_STAGES{1'b1}};
                    end
                end
                assign synced = chain[SYNC_STAGES-1];
            end else begin : g_nosync
                assign synced = sig_in[ch];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev <= 1'b0;
                end else begin
                    prev <= synced;
                end
            end

            assign rise[ch] = synced & ~prev;
        end
    endgenerate

endmodule

// File: rtl/dld_sep_meter.sv
// Pairs reference and feedback edges and reports the cycle distance.
module dld_sep_meter
    import dld_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_ref,
    input  logic             rise_fb,
    output logic             meas_valid,
    output logic [CNT_W-1:0] meas_sep
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    pair_st_t         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_d;
    logic [CNT_W-1:0] sep_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PAIR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        sep_d   = '0;
        unique case (state_q)
            PAIR_IDLE: begin
                if (rise_ref && rise_fb) begin
                    // coincident
                    done_d = 1'b1;
                    sep_d  = '0;
                end else if (rise_ref) begin
                    // start-ref
                    state_d = PAIR_WAIT_FB;
                    cnt_d   = CNT_ONE;
                end else if (rise_fb) begin
                    // start-fb
                    state_d = PAIR_WAIT_REF;
                    cnt_d   = CNT_ONE;
                end
            end
            PAIR_WAIT_FB: begin
                if (rise_fb) begin
                    // close
                    done_d  = 1'b1;
                    sep_d   = cnt_q;
                    state_d = PAIR_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q != CNT_MAX) begin
                    // repeat edges on ref do not restart the count
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            PAIR_WAIT_REF: begin
                if (rise_ref) begin
                    // close
                    done_d  = 1'b1;
                    sep_d   = cnt_q;
                    state_d = PAIR_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q != CNT_MAX) begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            default: begin
                state_d = PAIR_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_valid <= 1'b0;
            meas_sep   <= '0;
        end else begin
            meas_valid <= done_d;
            meas_sep   <= done_d ? sep_d : meas_sep;
        end
    end

endmodule

// File: rtl/dld_hyst_fsm.sv
// Two-threshold lock decision with a selectable window pair.
module dld_hyst_fsm
    import dld_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int LOCK_WIN0  = 10,
    parameter int UNLOCK_WIN0 = 15,
    parameter int LOCK_WIN1  = 4,
    parameter int UNLOCK_WIN1 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_valid,
    input  logic [CNT_W-1:0] meas_sep,
    input  logic             win_sel,
    input  logic             det_off,
    output logic             locked
);

    localparam int NSETS = 2;
    localparam logic [CNT_W-1:0] LK_TAB [NSETS] = '{CNT_W'(LOCK_WIN0),   CNT_W'(LOCK_WIN1)};
    localparam logic [CNT_W-1:0] UL_TAB [NSETS] = '{CNT_W'(UNLOCK_WIN0), CNT_W'(UNLOCK_WIN1)};

    lock_st_t         state_q, state_d;
    logic [CNT_W-1:0] lk_thr;
    logic [CNT_W-1:0] ul_thr;

    assign lk_thr = LK_TAB[win_sel];
    assign ul_thr = UL_TAB[win_sel];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_UNLOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (det_off) begin
            // disable
            state_d = LK_UNLOCKED;
        end else if (meas_valid) begin
            unique case (state_q)
                LK_UNLOCKED: if (meas_sep < lk_thr)  state_d = LK_LOCKED;   // acquire
                LK_LOCKED:   if (meas_sep >= ul_thr) state_d = LK_UNLOCKED; // lose
                default:     state_d = LK_UNLOCKED;
            endcase
        end
        // otherwise: hold
    end

    assign locked = (state_q == LK_LOCKED);

endmodule

// File: rtl/dld_lock_detect.sv
module dld_lock_detect #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_WIN0   = 10,
    parameter int UNLOCK_WIN0 = 15,
    parameter int LOCK_WIN1   = 4,
    parameter int UNLOCK_WIN1 = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic win_sel,
    input  logic det_off,
    input  logic pol_low,
    output logic status
);

    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;

    logic [1:0]       rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_sep;
    logic             lock_raw;

    dld_edge_det #(
        .CHANNELS    (2),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({fb_in, ref_in}),
        .rise   (rise)
    );

    dld_sep_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_ref   (rise[CH_REF]),
        .rise_fb    (rise[CH_FB]),
        .meas_valid (meas_valid),
        .meas_sep   (meas_sep)
    );

    dld_hyst_fsm #(
        .CNT_W       (CNT_W),
        .LOCK_WIN0   (LOCK_WIN0),
        .UNLOCK_WIN0 (UNLOCK_WIN0),
        .LOCK_WIN1   (LOCK_WIN1),
        .UNLOCK_WIN1 (UNLOCK_WIN1)
    ) u_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .meas_sep   (meas_sep),
        .win_sel    (win_sel),
        .det_off    (det_off),
        .locked     (lock_raw)
    );

    // Output process: gate, then apply polarity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else begin
            status <= (lock_raw & ~det_off) ^ pol_low;
        end
    end

endmodule

// File: rtl/dld_lock_detect_chk.sv
module dld_lock_detect_chk #(
    parameter int CNT_W       = 8,
    parameter int LOCK_WIN0   = 10,
    parameter int UNLOCK_WIN0 = 15,
    parameter int LOCK_WIN1   = 4,
    parameter int UNLOCK_WIN1 = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_sel,
    input logic             det_off,
    input logic             pol_low,
    input logic             status,
    input logic             meas_valid,
    input logic [CNT_W-1:0] meas_sep,
    input logic             lock_raw
);

    logic [CNT_W-1:0] lk_thr;
    logic [CNT_W-1:0] ul_thr;
    assign lk_thr = win_sel ? CNT_W'(LOCK_WIN1)   : CNT_W'(LOCK_WIN0);
    assign ul_thr = win_sel ? CNT_W'(UNLOCK_WIN1) : CNT_W'(UNLOCK_WIN0);

    // R3 R6
    acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid && (meas_sep < lk_thr) && !det_off |=> lock_raw);

    // R4 R6
    lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid && (meas_sep >= ul_thr) |=> !lock_raw);

    // R5 R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid && !det_off |=> lock_raw == $past(lock_raw));

    // R7
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_off |=> !lock_raw);

    // R8
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_raw) && $stable(pol_low) && !det_off |=> status != $past(status));

endmodule

bind dld_lock_detect dld_lock_detect_chk #(
    .CNT_W       (CNT_W),
    .LOCK_WIN0   (LOCK_WIN0),
    .UNLOCK_WIN0 (UNLOCK_WIN0),
    .LOCK_WIN1   (LOCK_WIN1),
    .UNLOCK_WIN1 (UNLOCK_WIN1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_sel    (win_sel),
    .det_off    (det_off),
    .pol_low    (pol_low),
    .status     (status),
    .meas_valid (meas_valid),
    .meas_sep   (meas_sep),
    .lock_raw   (lock_raw)
);

// File: tb/tb_dld_lock_detect.sv
module tb_dld_lock_detect;

    localparam int GAP = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic win_sel = 1'b0;
    logic det_off = 1'b0;
    logic pol_low = 1'b0;
    logic status;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit exp_lock = 1'b0;

    always #5 clk = ~clk;

    dld_lock_detect dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_in  (ref_in),
        .fb_in   (fb_in),
        .win_sel (win_sel),
        .det_off (det_off),
        .pol_low (pol_low),
        .status  (status)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    function automatic bit model(bit cur, int sep, bit ws);
        int lk = ws ? 4 : 10;
        int ul = ws ? 7 : 15;
        if (sep < lk) return 1'b1;
        if (sep >= ul) return 1'b0;
        return cur;
    endfunction

    task automatic check(string req);
        bit exp = exp_lock ^ pol_low;
        n_checks++;
        if (status !== exp) begin
            n_fail++;
            $display("FAIL %s: status actual=%b expected=%b", req, status, exp);
        end
    endtask

    // One-cycle pulses; second edge sep cycles after the first
    task automatic send_pair(int sep, bit fb_first);
        for (int t = 0; t <= sep; t++) begin
            @(negedge clk);
            ref_in = (t == (fb_first ? sep : 0));
            fb_in  = (t == (fb_first ? 0 : sep));
        end
        @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic pair_chk(int sep, bit fb_first, string req);
        send_pair(sep, fb_first);
        exp_lock = model(exp_lock, sep, win_sel);
        check(req);
    endtask

    task automatic pulse_one(bit is_ref);
        @(negedge clk);
        if (is_ref) ref_in = 1'b1; else fb_in = 1'b1;
        @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 reset unlocked");
        pol_low = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 R8 reset unlocked active low");
        pol_low = 1'b0;
        repeat (3) @(negedge clk);

        // Default windows, boundaries
        pair_chk(10, 1'b0, "R3 sep=10 no lock");
        pair_chk(9, 1'b0, "R3 sep=9 lock");
        pair_chk(14, 1'b1, "R5 sep=14 hold locked");
        pair_chk(15, 1'b1, "R4 sep=15 unlock");
        pair_chk(12, 1'b0, "R5 sep=12 hold unlocked");
        pair_chk(0, 1'b0, "R2 coincident lock");
        pair_chk(16, 1'b0, "R4 sep=16 unlock");
        pair_chk(9, 1'b1, "R2 fb first sep=9 lock");

        // Narrow windows
        win_sel = 1'b1;
        pair_chk(7, 1'b0, "R6 sep=7 unlock");
        pair_chk(4, 1'b1, "R6 sep=4 no lock");
        pair_chk(3, 1'b0, "R6 sep=3 lock");
        pair_chk(6, 1'b1, "R6 sep=6 hold");
        pair_chk(12, 1'b0, "R6 sep=12 unlock");
        win_sel = 1'b0;

        // Polarity
        pair_chk(2, 1'b0, "R3 lock before polarity");
        pol_low = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 locked active low");
        pol_low = 1'b0;
        repeat (3) @(negedge clk);

        // Disable
        det_off = 1'b1;
        repeat (3) @(negedge clk);
        exp_lock = 1'b0;
        check("R7 disabled forces unlocked");
        send_pair(1, 1'b0);
        check("R7 pair ignored while disabled");
        det_off = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 stays unlocked after enable");
        pair_chk(5, 1'b0, "R7 relock after enable");

        // Missing reference
        for (int i = 0; i < 5; i++) pulse_one(1'b0);
        check("R9 fb-only edges hold lock");
        pulse_one(1'b1);
        exp_lock = 1'b0;
        check("R9 late ref unlocks");

        // Repeated leading edge: ref@0, ref@6, fb@12 -> sep 12
        for (int t = 0; t <= 12; t++) begin
            @(negedge clk);
            ref_in = (t == 0) || (t == 6);
            fb_in  = (t == 12);
        end
        @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (GAP) @(negedge clk);
        exp_lock = model(exp_lock, 12, 1'b0);
        check("R10 repeated ref does not restart count");

        // Random
        for (int i = 0; i < 150; i++) begin
            int sep = int'($urandom_range(0, 20));
            bit ff = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) win_sel = ~win_sel;
            if ($urandom_range(0, 9) == 0) pol_low = ~pol_low;
            pair_chk(sep, ff, "R2 R3 R4 R5 R6 R8 random");
        end

        summary();
    end

endmodule